// File: doc/BRIEF.md
# Shift-Add Spiking Neuron Core

This block is a clocked spiking neuron built from a second-order recursive filter. Four binary spike inputs each gate a programmable signed 6-bit weight into a saturating sum, the drive. The drive feeds a filter that combines the current drive, the two previous drives and the two previous filter outputs. Each of these five taps is scaled by zero or by a signed power of two between one eighth and two, so the scaling needs only shifts and negation, with no multiplier. The filter output is the membrane value, and a registered comparator raises the spike output whenever the membrane is at or above a programmable threshold. All arithmetic stays in 6-bit two's complement, and every addition clamps to the range -32 to +31.

Firing leaves the filter state untouched. What happens after a spike depends only on the filter dynamics, so the membrane can stay above threshold for many cycles, or a later input can pull it back down, depending on when that input arrives. Software holds the core in a synchronous clear while it loads weights, threshold and coefficient codes through a small write port. A chain-select input swaps the synaptic drive for an external membrane value, so the output of one core can feed a second core. Two cores linked this way form a fourth-order response.

Top module: `spn_core`

## Requirements
- R1: The drive is formed by adding the weights of the inputs that spike in the cycle in ascending input order (input 0 first), clamping to [-32, 31] after each addition. An input without a spike adds nothing.
- R2: A 4-bit coefficient code scales a value as follows. Bit 3 is the sign (1 = negate). Bits 2:0 give the magnitude: 1 = times 2, 2 = times 1, 3 = half, 4 = quarter, 5 = eighth, and 0, 6 or 7 = zero. Fractions use an arithmetic right shift, which rounds toward minus infinity.
- R3: Each cycle the new membrane value is formed from the scaled taps in a fixed order. It starts as clamp(b0·x), then adds b1·x[n-1], then adds b2·x[n-2], then subtracts a1·y[n-1], then subtracts a2·y[n-2]. Every partial result is clamped to [-32, 31].
- R4: spike_out is 1 exactly when memb_out, read as signed, is greater than or equal to the signed threshold. Both outputs are registered and change on the same clock edge.
- R5: A spike does not modify the filter state, so consecutive spikes occur while the membrane stays at or above threshold.
- R6: While clr is high at a rising edge, the delay registers, the membrane and spike_out become zero. Loaded parameters keep their values.
- R7: Parameter addresses are 0 to 3 for the weights of inputs 0 to 3, 4 for the threshold, and 5 to 9 for the codes b0, b1, b2, a1, a2 (in the low 4 bits of cfg_data). A write takes effect only when cfg_we and clr are both high at the edge. A write to addresses 10 to 15, or a write made while clr is low, changes nothing.
- R8: When chain_sel is high, chain_in replaces the synaptic drive as the filter input, and spike inputs have no effect.
- R9: Pulling rst_n low clears the membrane, spike_out, the filter state and all parameters at once, without a clock. Release from reset takes effect two clock edges after rst_n rises.
- R10: Spike inputs present before a rising edge affect memb_out right after that edge (one cycle of latency through the b0 tap).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous state clear; also opens the parameter write window |
| spk_in | input | 4 | Binary spike inputs, one per synapse |
| cfg_we | input | 1 | Parameter write enable |
| cfg_addr | input | 4 | Parameter address |
| cfg_data | input | 6 | Parameter write data |
| chain_sel | input | 1 | Selects chain_in as the filter input |
| chain_in | input | 6 | External membrane value from another core, signed |
| memb_out | output | 6 | Registered membrane value, signed |
| spike_out | output | 1 | Registered spike output |

## Verification
Four properties are checked on every cycle. The spike output must agree with the membrane-versus-threshold comparison, a clear must leave a zero state, the parameters must stay unchanged outside the write window, and a threshold write must land. The bench scenarios cover what those properties cannot. These are the saturating order of the synaptic sum, the value of every coefficient code including the rounding of negative halves, the multi-cycle trajectory of a resonant configuration, chaining, and the persistence of spikes without self-reset. They also show that writes outside the window are ignored, and they cover the asynchronous reset that clears parameters along with state.

// File: rtl/spn_pkg.sv
`timescale 1ns/1ps
package spn_pkg;
  localparam int unsigned DW   = 6;          // data width of weights, threshold, state
  localparam int unsigned CW   = 4;          // coefficient code width
  localparam int unsigned XW   = DW + 3;     // headroom for one scaled term plus one add
  localparam int unsigned NSYN = 4;          // synapse count
  localparam int unsigned NTAP = 5;          // b0 b1 b2 a1 a2
  localparam int unsigned NFF  = 3;          // taps below this index are feed-forward
  localparam int unsigned AW   = 4;          // parameter address width
  localparam int unsigned NVAL = NSYN + 1;   // weights + threshold

  typedef logic signed [DW-1:0] sv_t;
  typedef logic signed [XW-1:0] xv_t;

  localparam xv_t XMAX = xv_t'((1 << (DW-1)) - 1);
  localparam xv_t XMIN = -xv_t'(1 << (DW-1));

  function automatic xv_t widen(input sv_t v);
    return xv_t'(v);
  endfunction

  function automatic sv_t clamp(input xv_t v);
    if (v > XMAX)      return sv_t'(XMAX);
    else if (v < XMIN) return sv_t'(XMIN);
    else               return sv_t'(v);
  endfunction
endpackage

// File: rtl/spn_rst_sync.sv
`timescale 1ns/1ps
module spn_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_q_n = sh_q[STAGES-1];
endmodule

// File: rtl/spn_param_bank.sv
`timescale 1ns/1ps
module spn_param_bank
  import spn_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 open,
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        data,
  output logic [NSYN*DW-1:0]   w_flat,
  output sv_t                  vth,
  output logic [NTAP*CW-1:0]   codes_flat
);
  for (genvar g = 0; g < NVAL; g++) begin : g_val
    logic          hit;
    logic [DW-1:0] v_q;
    assign hit = open && we && (addr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   v_q <= '0;
      else if (hit) v_q <= data;
    end
    if (g < NSYN) begin : g_w
      assign w_flat[g*DW +: DW] = v_q;
    end else begin : g_th
      assign vth = sv_t'(v_q);
    end
  end

  for (genvar t = 0; t < NTAP; t++) begin : g_cod
    logic          hit;
    logic [CW-1:0] c_q;
    assign hit = open && we && (addr == AW'(NVAL + t));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   c_q <= '0;
      else if (hit) c_q <= data[CW-1:0];
    end
    assign codes_flat[t*CW +: CW] = c_q;
  end
endmodule

// File: rtl/spn_syn_sum.sv
`timescale 1ns/1ps
module spn_syn_sum
  import spn_pkg::*;
(
  input  logic [NSYN-1:0]    spk,
  input  logic [NSYN*DW-1:0] w_flat,
  output sv_t                drive
);
  sv_t part [NSYN+1];
  assign part[0] = '0;

  for (genvar i = 0; i < NSYN; i++) begin : g_add
    sv_t gated;
    assign gated      = spk[i] ? sv_t'(w_flat[i*DW +: DW]) : '0;
    assign part[i+1]  = clamp(widen(part[i]) + widen(gated));
  end

  assign drive = part[NSYN];
endmodule

// File: rtl/spn_coef_mul.sv
`timescale 1ns/1ps
module spn_coef_mul
  import spn_pkg::*;
(
  input  logic [CW-1:0] code,
  input  sv_t           v,
  output xv_t           p
);
  xv_t vw;
  xv_t mag;

  always_comb begin
    vw = widen(v);
    case (code[CW-2:0])
      3'd1:    mag = vw <<< 1;
      3'd2:    mag = vw;
      3'd3:    mag = vw >>> 1;
      3'd4:    mag = vw >>> 2;
      3'd5:    mag = vw >>> 3;
      default: mag = '0;
    endcase
    p = code[CW-1] ? -mag : mag;
  end
endmodule

// File: rtl/spn_iir2.sv
`timescale 1ns/1ps
module spn_iir2
  import spn_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  sv_t                x_in,
  input  logic [NTAP*CW-1:0] codes_flat,
  input  sv_t                vth,
  output sv_t                memb,
  output logic               spike
);
  sv_t  x1_q, x2_q, y1_q, y2_q;
  sv_t  x1_d, x2_d, y1_d, y2_d;
  logic spk_q, spk_d;

  sv_t tap  [NTAP];
  xv_t prod [NTAP];
  sv_t acc  [NTAP];

  assign tap[0] = x_in;
  assign tap[1] = x1_q;
  assign tap[2] = x2_q;
  assign tap[3] = y1_q;
  assign tap[4] = y2_q;

  for (genvar g = 0; g < NTAP; g++) begin : g_mul
    spn_coef_mul u_mul (
      .code (codes_flat[g*CW +: CW]),
      .v    (tap[g]),
      .p    (prod[g])
    );
  end

  assign acc[0] = clamp(prod[0]);
  for (genvar g = 1; g < NTAP; g++) begin : g_acc
    if (g < NFF) begin : g_ff
      assign acc[g] = clamp(widen(acc[g-1]) + prod[g]);
    end else begin : g_fb
      assign acc[g] = clamp(widen(acc[g-1]) - prod[g]);
    end
  end

  always_comb begin
    if (clr) begin
      x1_d  = '0;
      x2_d  = '0;
      y1_d  = '0;
      y2_d  = '0;
      spk_d = 1'b0;
    end else begin
      x1_d  = x_in;
      x2_d  = x1_q;
      y1_d  = acc[NTAP-1];
      y2_d  = y1_q;
      spk_d = (acc[NTAP-1] >= vth);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x1_q  <= '0;
      x2_q  <= '0;
      y1_q  <= '0;
      y2_q  <= '0;
      spk_q <= 1'b0;
    end else begin
      x1_q  <= x1_d;
      x2_q  <= x2_d;
      y1_q  <= y1_d;
      y2_q  <= y2_d;
      spk_q <= spk_d;
    end
  end

  assign memb  = y1_q;
  assign spike = spk_q;
endmodule

// File: rtl/spn_core.sv
`timescale 1ns/1ps
module spn_core
  import spn_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [NSYN-1:0] spk_in,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [DW-1:0]   cfg_data,
  input  logic            chain_sel,
  input  logic [DW-1:0]   chain_in,
  output logic [DW-1:0]   memb_out,
  output logic            spike_out
);
  logic               rst_q_n;
  logic [NSYN*DW-1:0] w_flat;
  sv_t                vth;
  logic [NTAP*CW-1:0] codes_flat;
  sv_t                drive;
  sv_t                x_sel;
  sv_t                memb;

  spn_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  spn_param_bank u_prm (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .open       (clr),
    .we         (cfg_we),
    .addr       (cfg_addr),
    .data       (cfg_data),
    .w_flat     (w_flat),
    .vth        (vth),
    .codes_flat (codes_flat)
  );

  spn_syn_sum u_sum (
    .spk    (spk_in),
    .w_flat (w_flat),
    .drive  (drive)
  );

  assign x_sel = chain_sel ? sv_t'(chain_in) : drive;

  spn_iir2 u_iir (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .clr        (clr),
    .x_in       (x_sel),
    .codes_flat (codes_flat),
    .vth        (vth),
    .memb       (memb),
    .spike      (spike_out)
  );

  assign memb_out = memb;
endmodule

// File: rtl/spn_core_chk.sv
`timescale 1ns/1ps
module spn_core_chk
  import spn_pkg::*;
(
  input logic               clk,
  input logic               rst_q_n,
  input logic               clr,
  input logic               cfg_we,
  input logic [AW-1:0]      cfg_addr,
  input logic [DW-1:0]      cfg_data,
  input logic [DW-1:0]      memb_out,
  input logic               spike_out,
  input logic [NSYN*DW-1:0] w_flat,
  input sv_t                vth,
  input logic [NTAP*CW-1:0] codes_flat
);
  assert_spike_cmp_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    !$past(clr) |-> (spike_out == ($signed(memb_out) >= vth)));

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    $past(clr) |-> (memb_out == '0 && !spike_out));

  assert_prm_locked_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    !clr |=> ($stable(w_flat) && $stable(vth) && $stable(codes_flat)));

  assert_vth_write_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (clr && cfg_we && cfg_addr == AW'(NSYN)) |=> (vth == sv_t'($past(cfg_data))));
endmodule

bind spn_core spn_core_chk u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .clr        (clr),
  .cfg_we     (cfg_we),
  .cfg_addr   (cfg_addr),
  .cfg_data   (cfg_data),
  .memb_out   (memb_out),
  .spike_out  (spike_out),
  .w_flat     (w_flat),
  .vth        (vth),
  .codes_flat (codes_flat)
);

// File: tb/sim_spn_core.sv
`timescale 1ns/1ps
module sim_spn_core;
  localparam real CLK_NS = 4.0;

  logic       clk;
  logic       rst_n;
  logic       clr;
  logic [3:0] spk_in;
  logic       cfg_we;
  logic [3:0] cfg_addr;
  logic [5:0] cfg_data;
  logic       chain_sel;
  logic [5:0] chain_in;
  logic [5:0] memb_out;
  logic       spike_out;

  int n_vec  = 0;
  int n_fail = 0;

  int m_w [4];
  int m_vth;
  int m_c [5];
  int m_x1, m_x2, m_y1, m_y2, m_spk;

  spn_core u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .spk_in(spk_in),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .chain_sel(chain_sel), .chain_in(chain_in),
    .memb_out(memb_out), .spike_out(spike_out)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  function automatic int sat6(int v);
    if (v > 31)  return 31;
    if (v < -32) return -32;
    return v;
  endfunction

  function automatic int cmul(int code, int v);
    int m;
    case (code & 7)
      1: m = v * 2;
      2: m = v;
      3: m = v >>> 1;
      4: m = v >>> 2;
      5: m = v >>> 3;
      default: m = 0;
    endcase
    if ((code & 8) != 0) m = -m;
    return m;
  endfunction

  function automatic int memb_val();
    return int'($signed(memb_out));
  endfunction

  task automatic expect_int(string req, string what, int act, int exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_zero_all();
    for (int i = 0; i < 4; i++) m_w[i] = 0;
    for (int i = 0; i < 5; i++) m_c[i] = 0;
    m_vth = 0; m_x1 = 0; m_x2 = 0; m_y1 = 0; m_y2 = 0; m_spk = 0;
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cycle(logic [3:0] s, logic cs, int cin, logic cl,
                       logic we, int ad, int dt, string req);
    int x, y;
    spk_in = s; chain_sel = cs; chain_in = cin[5:0]; clr = cl;
    cfg_we = we; cfg_addr = ad[3:0]; cfg_data = dt[5:0];
    @(posedge clk);
    if (cl) begin
      m_x1 = 0; m_x2 = 0; m_y1 = 0; m_y2 = 0; m_spk = 0;
    end else begin
      if (cs) x = cin;
      else begin
        x = 0;
        for (int i = 0; i < 4; i++) if (s[i]) x = sat6(x + m_w[i]);
      end
      y = sat6(cmul(m_c[0], x));
      y = sat6(y + cmul(m_c[1], m_x1));
      y = sat6(y + cmul(m_c[2], m_x2));
      y = sat6(y - cmul(m_c[3], m_y1));
      y = sat6(y - cmul(m_c[4], m_y2));
      m_x2 = m_x1; m_x1 = x; m_y2 = m_y1; m_y1 = y;
      m_spk = (y >= m_vth) ? 1 : 0;
    end
    if (cl && we && ad < 10) begin
      if (ad < 4)       m_w[ad] = dt;
      else if (ad == 4) m_vth = dt;
      else              m_c[ad-5] = dt & 15;
    end
    @(negedge clk);
    expect_int(req, "memb", memb_val(), m_y1);
    expect_int(req, "spike", int'(spike_out), m_spk);
  endtask

  task automatic run(logic [3:0] s, string req);
    cycle(s, 1'b0, 0, 1'b0, 1'b0, 0, 0, req);
  endtask

  task automatic wr(int ad, int dt);
    cycle(4'b0, 1'b0, 0, 1'b1, 1'b1, ad, dt, "R7");
  endtask

  task automatic load(int w0, int w1, int w2, int w3, int th,
                      int b0, int b1, int b2, int a1, int a2);
    wr(0, w0); wr(1, w1); wr(2, w2); wr(3, w3); wr(4, th);
    wr(5, b0); wr(6, b1); wr(7, b2); wr(8, a1); wr(9, a2);
    cycle(4'b0, 1'b0, 0, 1'b1, 1'b0, 0, 0, "R6");
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    int vals [6] = '{-32, -17, -1, 1, 13, 31};
    rst_n = 1'b0; clr = 1'b1; spk_in = '0; cfg_we = 1'b0; cfg_addr = '0;
    cfg_data = '0; chain_sel = 1'b0; chain_in = '0;
    model_zero_all();
    repeat (3) @(negedge clk);
    expect_int("R9", "memb in reset", memb_val(), 0);
    expect_int("R9", "spike in reset", int'(spike_out), 0);
    rst_n = 1'b1;
    repeat (3) cycle(4'b0, 1'b0, 0, 1'b1, 1'b0, 0, 0, "R9");

    // R1 / R10: every input pattern, b0 = +1 only
    load(20, 15, -32, -5, 8, 2, 0, 0, 0, 0);
    for (int p = 0; p < 16; p++) begin
      run(4'(p), "R1");
      run(4'b0, "R10");
    end
    run(4'b0011, "R1");
    expect_int("R1", "saturated 20+15", memb_val(), 31);
    run(4'b1111, "R1");
    expect_int("R1", "ordered sum of all", memb_val(), -6);

    // R2 / R8: every coefficient code on b0, values through the chain input
    for (int c = 0; c < 16; c++) begin
      wr(5, c);
      for (int k = 0; k < 6; k++)
        cycle(4'b1111, 1'b1, vals[k], 1'b0, 1'b0, 0, 0, "R2");
      cycle(4'b0, 1'b0, 0, 1'b1, 1'b0, 0, 0, "R6");
    end
    wr(5, 1);
    cycle(4'b0, 1'b1, 20, 1'b0, 1'b0, 0, 0, "R2");
    expect_int("R2", "times two saturates", memb_val(), 31);
    wr(5, 11);
    cycle(4'b0, 1'b1, -17, 1'b0, 1'b0, 0, 0, "R2");
    expect_int("R2", "negated half of -17", memb_val(), 9);
    wr(5, 2);
    cycle(4'b1111, 1'b1, 13, 1'b0, 1'b0, 0, 0, "R8");
    expect_int("R8", "chain value ignores spikes", memb_val(), 13);

    // R3: resonant trajectory, inputs 0,1 at step 1 and input 2 at step 3
    load(10, 9, 12, -4, 20, 2, 3, 0, 10, 3);
    run(4'b0000, "R3");
    run(4'b0011, "R3");
    expect_int("R3", "first membrane step", memb_val(), 19);
    run(4'b0000, "R3");
    expect_int("R3", "resonant rise", memb_val(), 28);
    expect_int("R4", "spike at crossing", int'(spike_out), 1);
    run(4'b0100, "R3");
    for (int i = 0; i < 25; i++) run(4'b0000, "R3");

    // R5: held membrane keeps firing
    load(25, 0, 0, 0, 10, 2, 0, 0, 10, 0);
    run(4'b0001, "R5");
    for (int i = 0; i < 10; i++) run(4'b0000, "R5");
    expect_int("R5", "membrane held", memb_val(), 25);
    expect_int("R5", "still spiking", int'(spike_out), 1);

    // R6: clear mid-run keeps parameters
    cycle(4'b0, 1'b0, 0, 1'b1, 1'b0, 0, 0, "R6");
    expect_int("R6", "cleared membrane", memb_val(), 0);
    run(4'b0001, "R6");
    expect_int("R6", "weight retained", memb_val(), 25);

    // R7: writes outside window or to unused address change nothing
    cycle(4'b0, 1'b0, 0, 1'b0, 1'b1, 0, -7, "R7");
    cycle(4'b0, 1'b0, 0, 1'b1, 1'b1, 12, 5, "R7");
    cycle(4'b0, 1'b0, 0, 1'b1, 1'b0, 0, 0, "R7");
    run(4'b0001, "R7");
    expect_int("R7", "ignored write", memb_val(), 25);
    run(4'b0000, "R7");
    expect_int("R7", "threshold unchanged", int'(spike_out), 1);

    // R9: asynchronous reset clears state and parameters
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    expect_int("R9", "async memb clear", memb_val(), 0);
    expect_int("R9", "async spike clear", int'(spike_out), 0);
    model_zero_all();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) cycle(4'b0, 1'b0, 0, 1'b1, 1'b0, 0, 0, "R9");
    run(4'b0001, "R9");
    expect_int("R9", "parameters cleared", memb_val(), 0);

    summary();
    $finish;
  end
endmodule